// File: doc/BRIEF.md
# Four-Channel Line-Interface Pin Controller

This block manages the line-interface pins of four telephone channels through a small parallel register port. Each channel has two debounced status inputs, three bidirectional pins and two dedicated outputs. Software sees two views of the same pins. Global registers pack one bit per channel. A local register, steered by a 2-bit channel select, shows every pin of one channel.

Each pin class has its own write path. The direction and drive value of a bidirectional pin can be set only through that pin's global register. The two dedicated outputs can be set only through the local register. Status inputs, and bidirectional pins configured as inputs, can be read through both views. The two status inputs pass through a shift-register filter clocked by a slow sample tick before they reach the register views.

Reads are combinational from the address and channel select. Writes take effect on the clock edge at which the write strobe is high.

Top module: `line_pin_ctrl`

## Requirements
- R1: After reset, every bidirectional pin is an input (`sbOe` all 0), every drive latch and dedicated output is 0, and all filtered status values are 0.
- R2: A filtered status value changes only on a `sampleTick` cycle, and only after 8 consecutive ticks have sampled the same raw level. A shorter run of a new level leaves it unchanged.
- R3: Reading address 0 returns the filtered first status inputs of channels 1 to 4 in bits 0 to 3, and the filtered second status inputs in bits 4 to 7. Bit n belongs to channel n+1.
- R4: Writing address 1, 2 or 3 (bidirectional pin 1, 2 or 3) loads data bits 7:4 as that pin's direction for channels 1 to 4 (1 = output) and data bits 3:0 as its drive latches. From the next cycle, `sbOe` and `sbOut` at bit p*4+c follow these values for pin p+1 of channel c+1.
- R5: Reading address 1, 2 or 3 returns the direction in bits 7:4. Bits 3:0 hold, for each channel, the drive latch if the pin is an output, or the level on `sbIn` if it is an input.
- R6: Reading address 4 returns the channel picked by `chanSel` (0 = channel 1). The bits are: 0 filtered first status input, 1 filtered second status input, 2 to 4 bidirectional pins 1 to 3 (level as in R5), 5 first output latch, 6 second output latch, 7 zero.
- R7: Writing address 4 loads data bits 5 and 6 into the two output latches of the selected channel only. The other bits of the data are ignored, so no direction or drive latch changes.
- R8: The dedicated outputs change only through address 4. A write to any other address leaves `so1Out` and `so2Out` unchanged, and a read of address 4 returns the latched value of the most recent write.
- R9: Addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Slow sample enable for the status filters |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| chanSel | input | 2 | Channel picked for the local register view |
| regRdData | output | 8 | Read data for the current address |
| siIn1 | input | 4 | Raw first status input, one per channel |
| siIn2 | input | 4 | Raw second status input, one per channel |
| sbIn | input | 12 | Bidirectional pin levels, bit p*4+c for pin p+1 of channel c+1 |
| sbOut | output | 12 | Bidirectional pin drive values, same indexing |
| sbOe | output | 12 | Bidirectional pin output enables, same indexing |
| so1Out | output | 4 | First dedicated output per channel |
| so2Out | output | 4 | Second dedicated output per channel |

## Verification
The bench goes after the filter boundary: seven equal ticks followed by the eighth, and a glitch that splits a run. A filter that counts off by one would switch a tick early or late, and one without history would follow the glitch. It checks that a local write with every bit set leaves directions and drive latches alone, and that global writes leave the dedicated outputs alone. A design that crossed the write paths would change pins that software never addressed. Mixed directions are read back to catch a readback that returns the pin level where it should return the latch, or the reverse.

// File: rtl/line_pin_pkg.sv
package line_pin_pkg;
  localparam int NUM_CH = 4;
  localparam int NUM_SB = 3;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CH_W   = $clog2(NUM_CH);

  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SB1   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOCAL = 3'd4;

  // bit positions inside the local view
  localparam int LOC_SI1 = 0;
  localparam int LOC_SI2 = 1;
  localparam int LOC_SB0 = 2;
  localparam int LOC_SO1 = 5;
  localparam int LOC_SO2 = 6;

  typedef struct packed {
    logic              statSel;
    logic [NUM_SB-1:0] sbSel;
    logic [NUM_SB-1:0] sbWr;
    logic              locSel;
    logic              locWr;
    logic [NUM_CH-1:0] chanHot;
  } strobe_t;
endpackage

// File: rtl/line_pin_debounce.sv
module line_pin_debounce #(
  parameter int DEB_LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic rawIn,
  output logic filtOut
);
  logic [DEB_LEN-1:0] shiftQ;
  logic [DEB_LEN-1:0] shiftNext;

  assign shiftNext = {shiftQ[DEB_LEN-2:0], rawIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      filtOut <= 1'b0;
    end else if (tick) begin
      shiftQ <= shiftNext;
      if (&shiftNext)
        filtOut <= 1'b1;
      else if (~|shiftNext)
        filtOut <= 1'b0;
    end
  end
endmodule

// File: rtl/line_pin_ctl.sv
module line_pin_ctl
  import line_pin_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CH_W-1:0]   chanSel,
  output strobe_t           strb
);
  always_comb begin
    strb         = '0;
    strb.statSel = (regAddr == ADDR_STAT);
    strb.locSel  = (regAddr == ADDR_LOCAL);
    strb.locWr   = regWrEn && strb.locSel;
    for (int p = 0; p < NUM_SB; p++) begin
      strb.sbSel[p] = (regAddr == ADDR_W'(int'(ADDR_SB1) + p));
      strb.sbWr[p]  = regWrEn && strb.sbSel[p];
    end
    for (int c = 0; c < NUM_CH; c++)
      strb.chanHot[c] = (chanSel == CH_W'(c));
  end
endmodule

// File: rtl/line_pin_dp.sv
module line_pin_dp
  import line_pin_pkg::*;
#(
  parameter int DEB_LEN = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleTick,
  input  strobe_t                  strb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [CH_W-1:0]          chanSel,
  input  logic [NUM_CH-1:0]        siIn1,
  input  logic [NUM_CH-1:0]        siIn2,
  input  logic [NUM_SB*NUM_CH-1:0] sbIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_SB*NUM_CH-1:0] sbOut,
  output logic [NUM_SB*NUM_CH-1:0] sbOe,
  output logic [NUM_CH-1:0]        so1Out,
  output logic [NUM_CH-1:0]        so2Out,
  output logic [NUM_CH-1:0]        siFilt1,
  output logic [NUM_CH-1:0]        siFilt2
);
  logic [NUM_SB-1:0][NUM_CH-1:0] sbDirQ;
  logic [NUM_SB-1:0][NUM_CH-1:0] sbLatQ;
  logic [NUM_SB-1:0][NUM_CH-1:0] sbLevel;
  logic [NUM_CH-1:0]             so1Q;
  logic [NUM_CH-1:0]             so2Q;

  // status input filters, one pair per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_filt
    line_pin_debounce #(.DEB_LEN(DEB_LEN)) i_deb1 (
      .clk(clk), .rstN(rstN), .tick(sampleTick),
      .rawIn(siIn1[c]), .filtOut(siFilt1[c])
    );
    line_pin_debounce #(.DEB_LEN(DEB_LEN)) i_deb2 (
      .clk(clk), .rstN(rstN), .tick(sampleTick),
      .rawIn(siIn2[c]), .filtOut(siFilt2[c])
    );
  end

  // bidirectional pin state, written only by the global registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sbDirQ <= '0;
      sbLatQ <= '0;
    end else begin
      for (int p = 0; p < NUM_SB; p++) begin
        if (strb.sbWr[p]) begin
          sbDirQ[p] <= wrData[NUM_CH +: NUM_CH];
          sbLatQ[p] <= wrData[0 +: NUM_CH];
        end
      end
    end
  end

  // dedicated output latches, written only by the local register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      so1Q <= '0;
      so2Q <= '0;
    end else if (strb.locWr) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (strb.chanHot[c]) begin
          so1Q[c] <= wrData[LOC_SO1];
          so2Q[c] <= wrData[LOC_SO2];
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_SB; p++) begin : g_level
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign sbLevel[p][c] = sbDirQ[p][c] ? sbLatQ[p][c] : sbIn[p*NUM_CH + c];
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.statSel)
      rdData = DATA_W'({siFilt2, siFilt1});
    for (int p = 0; p < NUM_SB; p++) begin
      if (strb.sbSel[p])
        rdData = DATA_W'({sbDirQ[p], sbLevel[p]});
    end
    if (strb.locSel) begin
      rdData[LOC_SI1] = siFilt1[chanSel];
      rdData[LOC_SI2] = siFilt2[chanSel];
      for (int p = 0; p < NUM_SB; p++)
        rdData[LOC_SB0 + p] = sbLevel[p][chanSel];
      rdData[LOC_SO1] = so1Q[chanSel];
      rdData[LOC_SO2] = so2Q[chanSel];
    end
  end

  assign sbOe   = sbDirQ;
  assign sbOut  = sbLatQ;
  assign so1Out = so1Q;
  assign so2Out = so2Q;
endmodule

// File: rtl/line_pin_ctrl.sv
module line_pin_ctrl
  import line_pin_pkg::*;
#(
  parameter int DEB_LEN = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleTick,
  input  logic                     regWrEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWrData,
  input  logic [CH_W-1:0]          chanSel,
  output logic [DATA_W-1:0]        regRdData,
  input  logic [NUM_CH-1:0]        siIn1,
  input  logic [NUM_CH-1:0]        siIn2,
  input  logic [NUM_SB*NUM_CH-1:0] sbIn,
  output logic [NUM_SB*NUM_CH-1:0] sbOut,
  output logic [NUM_SB*NUM_CH-1:0] sbOe,
  output logic [NUM_CH-1:0]        so1Out,
  output logic [NUM_CH-1:0]        so2Out
);
  strobe_t           strb;
  logic [NUM_CH-1:0] siFilt1;
  logic [NUM_CH-1:0] siFilt2;

  line_pin_ctl i_ctl (
    .regWrEn(regWrEn), .regAddr(regAddr), .chanSel(chanSel), .strb(strb)
  );

  line_pin_dp #(.DEB_LEN(DEB_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .strb(strb),
    .wrData(regWrData), .chanSel(chanSel), .siIn1(siIn1), .siIn2(siIn2),
    .sbIn(sbIn), .rdData(regRdData), .sbOut(sbOut), .sbOe(sbOe),
    .so1Out(so1Out), .so2Out(so2Out), .siFilt1(siFilt1), .siFilt2(siFilt2)
  );
endmodule

// File: rtl/line_pin_ctrl_chk.sv
module line_pin_ctrl_chk
  import line_pin_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleTick,
  input logic                     regWrEn,
  input logic [ADDR_W-1:0]        regAddr,
  input logic [DATA_W-1:0]        regWrData,
  input logic [CH_W-1:0]          chanSel,
  input logic [DATA_W-1:0]        regRdData,
  input logic [NUM_SB*NUM_CH-1:0] sbOut,
  input logic [NUM_SB*NUM_CH-1:0] sbOe,
  input logic [NUM_CH-1:0]        so1Out,
  input logic [NUM_CH-1:0]        so2Out,
  input logic [NUM_CH-1:0]        siFilt1,
  input logic [NUM_CH-1:0]        siFilt2
);
  logic sbWrAny;
  logic locWr;
  assign sbWrAny = regWrEn && (regAddr >= ADDR_SB1) && (regAddr < ADDR_LOCAL);
  assign locWr   = regWrEn && (regAddr == ADDR_LOCAL);

  assert_filt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(siFilt1) && $stable(siFilt2));

  assert_sb_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !sbWrAny |=> $stable(sbOe) && $stable(sbOut));

  assert_sb1_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_SB1) |=>
      sbOe[NUM_CH-1:0] == $past(regWrData[2*NUM_CH-1:NUM_CH]) &&
      sbOut[NUM_CH-1:0] == $past(regWrData[NUM_CH-1:0]));

  assert_so_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    locWr |=> so1Out[$past(chanSel)] == $past(regWrData[LOC_SO1]) &&
              so2Out[$past(chanSel)] == $past(regWrData[LOC_SO2]));

  assert_so_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !locWr |=> $stable(so1Out) && $stable(so2Out));

  assert_so_onech_R7: assert property (@(posedge clk) disable iff (!rstN)
    locWr |=> $countones((so1Out ^ $past(so1Out)) | (so2Out ^ $past(so2Out))) <= 1);

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > ADDR_LOCAL) |-> regRdData == '0);
endmodule

bind line_pin_ctrl line_pin_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .chanSel(chanSel),
  .regRdData(regRdData), .sbOut(sbOut), .sbOe(sbOe), .so1Out(so1Out),
  .so2Out(so2Out), .siFilt1(siFilt1), .siFilt2(siFilt2)
);

// File: tb/test_line_pin_ctrl.sv
module test_line_pin_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [1:0]  chanSel = '0;
  logic [7:0]  regRdData;
  logic [3:0]  siIn1 = '0;
  logic [3:0]  siIn2 = '0;
  logic [11:0] sbIn = '0;
  logic [11:0] sbOut, sbOe;
  logic [3:0]  so1Out, so2Out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [3:0] mDir [3];
  logic [3:0] mLat [3];
  logic [3:0] mSo1, mSo2, mF1, mF2;
  logic [7:0] mSh1 [4];
  logic [7:0] mSh2 [4];

  always #2 clk = ~clk;

  line_pin_ctrl i_line_pin_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .chanSel(chanSel),
    .regRdData(regRdData), .siIn1(siIn1), .siIn2(siIn2), .sbIn(sbIn),
    .sbOut(sbOut), .sbOe(sbOe), .so1Out(so1Out), .so2Out(so2Out)
  );

  function automatic logic sbLvl(int p, int c);
    return mDir[p][c] ? mLat[p][c] : sbIn[p*4 + c];
  endfunction

  function automatic logic [7:0] expRead(logic [2:0] a, int c);
    logic [7:0] r = '0;
    if (a == 0) r = {mF2, mF1};
    else if (a <= 3) begin
      r[7:4] = mDir[a-1];
      for (int k = 0; k < 4; k++) r[k] = sbLvl(a-1, k);
    end else if (a == 4) begin
      r[0] = mF1[c];
      r[1] = mF2[c];
      for (int p = 0; p < 3; p++) r[2+p] = sbLvl(p, c);
      r[5] = mSo1[c];
      r[6] = mSo2[c];
    end
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int p = 0; p < 3; p++) begin mDir[p] = '0; mLat[p] = '0; end
    mSo1 = '0; mSo2 = '0; mF1 = '0; mF2 = '0;
    for (int c = 0; c < 4; c++) begin mSh1[c] = '0; mSh2[c] = '0; end
  endtask

  task automatic doWrite(logic [2:0] a, logic [7:0] d, logic [1:0] c);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; chanSel = c;
    if (a >= 1 && a <= 3) begin mDir[a-1] = d[7:4]; mLat[a-1] = d[3:0]; end
    if (a == 4) begin mSo1[c] = d[5]; mSo2[c] = d[6]; end
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk);
    sampleTick = 1'b1;
    for (int c = 0; c < 4; c++) begin
      mSh1[c] = {mSh1[c][6:0], siIn1[c]};
      mSh2[c] = {mSh2[c][6:0], siIn2[c]};
      if (mSh1[c] == 8'hff) mF1[c] = 1'b1; else if (mSh1[c] == 8'h00) mF1[c] = 1'b0;
      if (mSh2[c] == 8'hff) mF2[c] = 1'b1; else if (mSh2[c] == 8'h00) mF2[c] = 1'b0;
    end
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic readChk(logic [2:0] a, logic [1:0] c, string req);
    @(negedge clk);
    regAddr = a; chanSel = c;
    #1;
    chk(req, $sformatf("read addr=%0d ch=%0d", a, c), regRdData, expRead(a, c));
  endtask

  task automatic portChk(string tag);
    #1;
    chk({tag, " R4"}, "sbOe", sbOe, {mDir[2], mDir[1], mDir[0]});
    chk({tag, " R4"}, "sbOut", sbOut, {mLat[2], mLat[1], mLat[0]});
    chk({tag, " R8"}, "so1Out", so1Out, mSo1);
    chk({tag, " R8"}, "so2Out", so2Out, mSo2);
  endtask

  task automatic fullChk(string tag);
    portChk(tag);
    readChk(3'd0, 2'd0, {tag, " R3"});
    for (int a = 1; a <= 3; a++) readChk(3'(a), 2'd0, {tag, " R5"});
    for (int c = 0; c < 4; c++) readChk(3'd4, 2'(c), {tag, " R6"});
    for (int a = 5; a <= 7; a++) readChk(3'(a), 2'd0, {tag, " R9"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    fullChk("R1");

    // R2: filter boundary on channel 1 first input
    siIn1[0] = 1'b1;
    repeat (7) doTick();
    readChk(3'd0, 2'd0, "R2 seven ticks");
    chk("R2", "filt after 7", {31'd0, regRdData[0]}, 32'd0);
    doTick();
    readChk(3'd0, 2'd0, "R2 eighth tick");
    chk("R2", "filt after 8", {31'd0, regRdData[0]}, 32'd1);
    // glitch splits the run
    siIn1[0] = 1'b0; repeat (3) doTick();
    siIn1[0] = 1'b1; doTick();
    siIn1[0] = 1'b0; repeat (7) doTick();
    readChk(3'd0, 2'd0, "R2 glitch");
    chk("R2", "filt after glitch", {31'd0, regRdData[0]}, 32'd1);
    doTick();
    readChk(3'd0, 2'd0, "R2 eight zeros");
    chk("R2", "filt after 8 zeros", {31'd0, regRdData[0]}, 32'd0);

    // R4/R5: mixed directions
    sbIn = 12'h000;
    doWrite(3'd1, 8'h5F, 2'd0);
    doWrite(3'd3, 8'hA3, 2'd0);
    fullChk("R4 R5 mixed");

    // R7: local write with all bits set touches only outputs of channel 3
    doWrite(3'd4, 8'hFF, 2'd2);
    fullChk("R7 local all-ones");
    chk("R7", "so1Out ch3 only", so1Out, 32'h4);

    // R8: global writes leave dedicated outputs alone
    doWrite(3'd2, 8'hFF, 2'd2);
    doWrite(3'd1, 8'h00, 2'd1);
    fullChk("R8 global");

    // R9: unmapped writes change nothing
    for (int a = 5; a <= 7; a++) doWrite(3'(a), 8'hFF, 2'd1);
    fullChk("R9 unmapped");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) doWrite(3'($urandom_range(1, 3)), 8'($urandom), 2'($urandom));
      else if (op < 5) doWrite(3'd4, 8'($urandom), 2'($urandom));
      else if (op == 5) doWrite(3'($urandom_range(5, 7)), 8'($urandom), 2'($urandom));
      else begin
        if ($urandom_range(0, 15) == 0) siIn1 = 4'($urandom);
        if ($urandom_range(0, 15) == 0) siIn2 = 4'($urandom);
        if ($urandom_range(0, 3) == 0) sbIn = 12'($urandom);
        doTick();
      end
      portChk("rand");
      readChk(3'($urandom_range(0, 7)), 2'($urandom), "rand R2 R3 R5 R6 R9");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule